// File: doc/BRIEF.md
# Low-Memory Chip Select

This block generates an active-low chip select for the bottom of a 20-bit memory space. A 16-bit control word, written over a single-cycle register port, sets how far up from address 0 the selected block reaches. It also sets the wait-state count and ready policy reported while the select is active, and whether the address is driven onto the shared address/data lines during the address phase.

After reset the select stays inactive until the first write to the control word. The value written does not matter. A strap pin is captured on the first clock after reset release. When that strap reads 0, the address is always driven, whatever the disable-address bit says. The select is registered: it is decided from the address-phase strobe and held until the bus cycle ends.

Top module: `lowmem_csel`

## Requirements
- R1: After reset `sel_n` is 1 and `rd_data` reads 16'h0F00 (disable-address bit 7 is 0, bits 11:8 are 1). A memory cycle to address 0 before any register write leaves `sel_n` at 1.
- R2: Any pulse of `reg_wr`, including one writing 16'h0000, arms the select for all later cycles.
- R3: With boundary field bits 14:12 at 000, 001, 011 or 111, the select covers addresses 00000h up to 0FFFFh, 1FFFFh, 3FFFFh or 7FFFFh respectively. An address above the boundary does not select.
- R4: For other boundary codes, the size follows the longest run of ones starting at bit 12 (010 gives 64K, 101 gives 128K, 110 gives 64K).
- R5: A cycle with `cyc_mem` at 0 (an I/O cycle) never asserts `sel_n`.
- R6: `sel_n` takes its decoded value one clock after `addr_valid`. It holds until the clock after `cyc_end` pulses, and then returns to 1.
- R7: While `sel_n` is 0, `wait_cnt` equals bits 1:0 and `ign_ready` equals bit 2. While `sel_n` is 1, both are 0.
- R8: `rd_data` always returns bit 15 and bits 6:3 as 0 and bits 11:8 as 1. The other bits return what was written (16'hFFFF reads 16'h7F87).
- R9: With the strap sampled as 1, `addr_drive_en` is the inverse of bit 7.
- R10: With the strap sampled as 0, `addr_drive_en` is 1 for any value of bit 7. Changing `strap_n` after the sample has no effect.
- R11: A new reset clears bit 7 and disarms the select, even after it was armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_n | input | 1 | Address-drive strap, sampled once after reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Control word write data |
| rd_data | output | 16 | Control word read-back |
| addr_valid | input | 1 | Address-phase strobe of a bus cycle |
| cyc_mem | input | 1 | 1 for a memory cycle, 0 for I/O |
| addr | input | 20 | Bus cycle address |
| cyc_end | input | 1 | End of the data phase |
| sel_n | output | 1 | Low-memory select, active low |
| wait_cnt | output | 2 | Wait states for the selected cycle |
| ign_ready | output | 1 | External ready ignored for the selected cycle |
| addr_drive_en | output | 1 | Drive the address in the address phase |

## Verification
A wrong arm flag appears as a select either firing before the first write or missing after it, on the first bus cycle that follows. A corrupted boundary field shows as a wrong `sel_n` one clock after the address strobe on a cycle just past a boundary, so vectors straddle every edge. A lost strap sample shows on `addr_drive_en` as soon as bit 7 is written as 1.

// File: rtl/lowmem_csel.sv
module lowmem_csel #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strap_n,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] rd_data,
  input  logic          addr_valid,
  input  logic          cyc_mem,
  input  logic [AW-1:0] addr,
  input  logic          cyc_end,
  output logic          sel_n,
  output logic [1:0]    wait_cnt,
  output logic          ign_ready,
  output logic          addr_drive_en
);

  logic [2:0] ub;
  logic       dis_addr, ign_bit, armed, strap_q, strap_done, sel_q;
  logic [1:0] ws;
  logic [2:0] allow;
  logic       hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ub       <= '0;
      dis_addr <= 1'b0;
      ign_bit  <= 1'b0;
      ws       <= '0;
      armed    <= 1'b0;
    end else if (reg_wr) begin
      ub       <= reg_wdata[14:12];
      dis_addr <= reg_wdata[7];
      ign_bit  <= reg_wdata[2];
      ws       <= reg_wdata[1:0];
      armed    <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q    <= 1'b1;
      strap_done <= 1'b0;
    end else if (!strap_done) begin
      strap_q    <= strap_n;
      strap_done <= 1'b1;
    end
  end

  assign allow = {&ub, &ub[1:0], ub[0]};
  assign hit   = !addr[AW-1] && ((addr[AW-2:AW-4] & ~allow) == 3'b000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sel_q <= 1'b0;
    else if (addr_valid) sel_q <= armed && cyc_mem && hit;
    else if (cyc_end)    sel_q <= 1'b0;
  end

  assign sel_n         = !sel_q;
  assign wait_cnt      = sel_q ? ws : 2'b00;
  assign ign_ready     = sel_q && ign_bit;
  assign addr_drive_en = !dis_addr || !strap_q;
  assign rd_data       = {1'b0, ub, 4'hF, dis_addr, 4'b0000, ign_bit, ws};

endmodule

// File: rtl/lowmem_csel_chk.sv
module lowmem_csel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        armed,
  input logic        addr_valid,
  input logic        cyc_mem,
  input logic        cyc_end,
  input logic [19:0] addr,
  input logic        sel_n,
  input logic [1:0]  wait_cnt,
  input logic        ign_ready,
  input logic        addr_drive_en,
  input logic [15:0] rd_data
);

  p_unarmed_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> sel_n);

  p_top_bit_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && addr[19] |=> sel_n);

  p_io_never_r5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !cyc_mem |=> sel_n);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_n && !addr_valid && !cyc_end |=> !sel_n);

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end && !addr_valid |=> sel_n);

  p_idle_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |-> (wait_cnt == 2'b00) && !ign_ready);

  p_fixed_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[15] == 1'b0 && rd_data[11:8] == 4'hF && rd_data[6:3] == 4'h0);

  p_drive_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[7] |-> addr_drive_en);

endmodule

bind lowmem_csel lowmem_csel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .armed(armed), .addr_valid(addr_valid),
  .cyc_mem(cyc_mem), .cyc_end(cyc_end), .addr(addr), .sel_n(sel_n),
  .wait_cnt(wait_cnt), .ign_ready(ign_ready), .addr_drive_en(addr_drive_en),
  .rd_data(rd_data)
);

// File: tb/lowmem_csel_test.sv
module lowmem_csel_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;
  // {ub[2:0], mem, addr[19:0], expected select}
  localparam logic [24:0] VEC [NV] = '{
    {3'b000, 1'b1, 20'h0FFFF, 1'b1},
    {3'b000, 1'b1, 20'h10000, 1'b0},
    {3'b001, 1'b1, 20'h1FFFF, 1'b1},
    {3'b001, 1'b1, 20'h20000, 1'b0},
    {3'b011, 1'b1, 20'h3FFFF, 1'b1},
    {3'b011, 1'b1, 20'h40000, 1'b0},
    {3'b111, 1'b1, 20'h7FFFF, 1'b1},
    {3'b111, 1'b1, 20'h80000, 1'b0},
    {3'b111, 1'b0, 20'h00100, 1'b0},
    {3'b010, 1'b1, 20'h10000, 1'b0},
    {3'b101, 1'b1, 20'h1FFFF, 1'b1},
    {3'b110, 1'b1, 20'h0FFFF, 1'b1},
    {3'b101, 1'b1, 20'h20000, 1'b0}
  };

  logic clk = 0, rst_n = 0, strap_n = 1, reg_wr = 0, addr_valid = 0, cyc_mem = 0, cyc_end = 0;
  logic [15:0] reg_wdata = '0, rd_data;
  logic [19:0] addr = '0;
  logic sel_n, ign_ready, addr_drive_en;
  logic [1:0] wait_cnt;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lowmem_csel uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] v);
    @(negedge clk); reg_wr = 1; reg_wdata = v;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic cyc_start(input logic [19:0] a, input logic m);
    @(negedge clk); addr_valid = 1; addr = a; cyc_mem = m;
    @(negedge clk); addr_valid = 0;
  endtask

  task automatic cyc_stop;
    @(negedge clk); cyc_end = 1;
    @(negedge clk); cyc_end = 0;
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk); rst_n = 0; strap_n = s;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset(1'b1);
    chk("R1 sel_n after reset", sel_n, 1);
    chk("R1 rd_data after reset", rd_data, 16'h0F00);
    chk("R11 drive after reset", addr_drive_en, 1);
    cyc_start(20'h00000, 1'b1);
    chk("R1 no select before write", sel_n, 1);
    cyc_stop();

    wr(16'h0000);
    cyc_start(20'h00000, 1'b1);
    chk("R2 armed by zero write", sel_n, 0);
    chk("R7 wait zero", wait_cnt, 0);
    repeat (3) @(negedge clk);
    chk("R6 held through data phase", sel_n, 0);
    cyc_stop();
    chk("R6 released after end", sel_n, 1);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] u;
      logic m, e;
      logic [19:0] a;
      {u, m, a, e} = VEC[i];
      wr({1'b0, u, 9'h000, i[2], i[1:0]});
      cyc_start(a, m);
      chk(m ? (u inside {3'b000, 3'b001, 3'b011, 3'b111} ? "R3 range" : "R4 odd code")
            : "R5 io cycle", !sel_n, e);
      chk("R7 wait_cnt", wait_cnt, e ? i[1:0] : 2'b00);
      chk("R7 ign_ready", ign_ready, e ? i[2] : 1'b0);
      cyc_stop();
      chk("R6 end release", sel_n, 1);
    end

    wr(16'hFFFF);
    chk("R8 readback ones", rd_data, 16'h7F87);
    chk("R9 strap1 DA1", addr_drive_en, 0);
    wr(16'h1003);
    chk("R8 readback mix", rd_data, 16'h1F03);
    chk("R9 strap1 DA0", addr_drive_en, 1);
    wr(16'h0080);
    strap_n = 0;
    repeat (2) @(negedge clk);
    chk("R10 late strap ignored", addr_drive_en, 0);

    do_reset(1'b1);
    chk("R11 DA cleared", rd_data[7], 0);
    cyc_start(20'h00010, 1'b1);
    chk("R11 disarmed", sel_n, 1);
    cyc_stop();

    do_reset(1'b0);
    strap_n = 1;
    wr(16'h0080);
    chk("R10 strap0 forces drive", addr_drive_en, 1);
    wr(16'h0000);
    chk("R10 strap0 DA0", addr_drive_en, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule